// File: doc/BRIEF.md
# Read-Side Queue Selector with Fall-Through Switching

This block sits at the read port of a multi-queue FIFO. It decodes an 8-bit read address bus under two strobes. The queue strobe picks which of 16 queues feeds the output. The sector strobe picks which half of the almost-empty flags the flag bus shows. The block drives one pop strobe per queue and a select for the output multiplexer. The queue storage and the output register sit outside the block. The register loads the head word of the queue named by `out_sel` on every edge where that queue's pop strobe is high.

A queue change needs two clock edges. The edge that latches the new queue leaves the old queue current. The next edge moves one more word out of the old queue, whether or not read enable is high. The edge after that moves the new queue's head word out on its own, which is the first-word-fall-through behaviour. Several devices can share one address bus. The top three address bits carry a device number, and a strobe takes effect only when that number matches the local `dev_id`.

Top module: `rd_queue_sel`

## Requirements
- R1: When `addr_stb` is high and `rd_addr[7:5]` equals `dev_id`, the queue in `rd_addr[3:0]` is latched on that edge whatever `rd_en` is. `out_sel` shows it from the second edge after the select.
- R2: On the first edge after a queue select, the previously current queue is popped once whether or not `rd_en` is high, provided it is not empty.
- R3: On the second edge after a queue select, the newly selected queue is popped once whether or not `rd_en` is high, provided it is not empty. Its head word is then on the output.
- R4: Outside a switch, the current queue is popped once on each edge where `rd_en` is high and not at all when `rd_en` is low.
- R5: A pop is never issued to a queue whose `q_empty` bit is high. A read or forced read on an empty queue is ignored and the output keeps its last word.
- R6: When `sect_stb` is high, `addr_stb` is low and the device bits match, `sector_sel` takes `rd_addr[0]` on that edge. Bits 4:1 have no effect and no `rd_en` is needed. A read with `rd_en` may advance on the same edge.
- R7: A queue or sector strobe whose `rd_addr[7:5]` differs from `dev_id` changes neither the current queue, the pops, nor `sector_sel`.
- R8: `addr_stb` and `sect_stb` high in the same cycle set `proto_err` high for the one cycle after that edge. The queue select is carried out and `sector_sel` keeps its value.
- R9: After reset, the current queue is 0, `sector_sel` and `proto_err` are 0, and `q_pop` has at most one bit set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | input | 8 | Device number [7:5], queue number [3:0], sector bit [0] |
| addr_stb | input | 1 | Queue-select strobe |
| sect_stb | input | 1 | Flag-sector-select strobe |
| rd_en | input | 1 | Read enable for the current queue |
| dev_id | input | 3 | Local device number for cascading |
| q_empty | input | 16 | Per-queue empty flags from storage |
| q_pop | output | 16 | Per-queue pop strobes, one-hot or zero |
| out_sel | output | 4 | Queue feeding the output register |
| sector_sel | output | 1 | Almost-empty flag sector shown on the flag bus |
| proto_err | output | 1 | Both strobes seen together on the previous edge |

## Verification
The checker assumes that `dev_id` stays fixed after reset. It also assumes that `q_empty` comes from registered storage state and only changes on clock edges, so a forced pop can be judged against the empty flag of the same cycle. The bench sets `dev_id` once before reset and changes every input 1 ns after a rising edge. It derives the empty flags from its own per-queue storage model, which updates only at the rising edge. Every strobe is held for exactly one cycle, apart from deliberate overlap and mismatch cases.

// File: rtl/rqs_pkg.sv
package rqs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FILL  = 2'd2
  } sw_stage_e;

  function automatic logic stage_forces_pop(input sw_stage_e st);
    return (st == ST_DRAIN) || (st == ST_FILL);
  endfunction

  function automatic sw_stage_e next_stage(input sw_stage_e st, input logic sel);
    if (sel) return ST_DRAIN;
    case (st)
      ST_DRAIN: return ST_FILL;
      default:  return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/rqs_decode.sv
module rqs_decode #(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 3,
  parameter int QSEL_W = 4
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              addr_stb,
  input  logic              sect_stb,
  input  logic [ID_W-1:0]   dev_id,
  output logic              q_sel_evt,
  output logic              sect_evt,
  output logic              stb_clash,
  output logic [QSEL_W-1:0] new_q,
  output logic              new_sect
);

  function automatic logic id_hit(input logic [ADDR_W-1:0] a, input logic [ID_W-1:0] id);
    return a[ADDR_W-1 -: ID_W] == id;
  endfunction

  logic hit;
  logic unused_mid_bits;

  assign hit             = id_hit(rd_addr, dev_id);
  assign q_sel_evt       = addr_stb && hit;
  assign sect_evt        = sect_stb && !addr_stb && hit;
  assign stb_clash       = addr_stb && sect_stb;
  assign new_q           = rd_addr[QSEL_W-1:0];
  assign new_sect        = rd_addr[0];
  assign unused_mid_bits = ^rd_addr;

endmodule

// File: rtl/rqs_switch_seq.sv
module rqs_switch_seq
  import rqs_pkg::*;
#(
  parameter int QSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_sel_evt,
  input  logic [QSEL_W-1:0] new_q,
  output logic [QSEL_W-1:0] cur_q,
  output logic              force_pop
);

  sw_stage_e         stage;
  logic [QSEL_W-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      pend_q <= '0;
      stage  <= ST_IDLE;
    end else begin
      if (stage == ST_DRAIN) cur_q <= pend_q;
      if (q_sel_evt) pend_q <= new_q;
      stage <= next_stage(stage, q_sel_evt);
    end
  end

  assign force_pop = stage_forces_pop(stage);

endmodule

// File: rtl/rqs_pop_gen.sv
module rqs_pop_gen #(
  parameter int NUM_Q  = 16,
  parameter int QSEL_W = 4
) (
  input  logic [QSEL_W-1:0] cur_q,
  input  logic              want_pop,
  input  logic [NUM_Q-1:0]  q_empty,
  output logic [NUM_Q-1:0]  q_pop
);

  for (genvar i = 0; i < NUM_Q; i++) begin : g_pop
    assign q_pop[i] = want_pop && (cur_q == QSEL_W'(i)) && !q_empty[i];
  end

endmodule

// File: rtl/rd_queue_sel.sv
module rd_queue_sel #(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 3,
  parameter int NUM_Q  = 16,
  localparam int QSEL_W = $clog2(NUM_Q)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              addr_stb,
  input  logic              sect_stb,
  input  logic              rd_en,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [NUM_Q-1:0]  q_empty,
  output logic [NUM_Q-1:0]  q_pop,
  output logic [QSEL_W-1:0] out_sel,
  output logic              sector_sel,
  output logic              proto_err
);

  logic              q_sel_evt;
  logic              sect_evt;
  logic              stb_clash;
  logic [QSEL_W-1:0] new_q;
  logic              new_sect;
  logic              force_pop;
  logic              want_pop;

  rqs_decode #(.ADDR_W(ADDR_W), .ID_W(ID_W), .QSEL_W(QSEL_W)) u_dec (
    .rd_addr   (rd_addr),
    .addr_stb  (addr_stb),
    .sect_stb  (sect_stb),
    .dev_id    (dev_id),
    .q_sel_evt (q_sel_evt),
    .sect_evt  (sect_evt),
    .stb_clash (stb_clash),
    .new_q     (new_q),
    .new_sect  (new_sect)
  );

  rqs_switch_seq #(.QSEL_W(QSEL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_sel_evt (q_sel_evt),
    .new_q     (new_q),
    .cur_q     (out_sel),
    .force_pop (force_pop)
  );

  assign want_pop = force_pop || rd_en;

  rqs_pop_gen #(.NUM_Q(NUM_Q), .QSEL_W(QSEL_W)) u_pop (
    .cur_q    (out_sel),
    .want_pop (want_pop),
    .q_empty  (q_empty),
    .q_pop    (q_pop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sector_sel <= 1'b0;
      proto_err  <= 1'b0;
    end else begin
      if (sect_evt) sector_sel <= new_sect;
      proto_err <= stb_clash;
    end
  end

endmodule

// File: rtl/rqs_checker.sv
module rqs_checker #(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 3,
  parameter int NUM_Q  = 16,
  localparam int QSEL_W = $clog2(NUM_Q)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              addr_stb,
  input logic              sect_stb,
  input logic [ID_W-1:0]   dev_id,
  input logic [NUM_Q-1:0]  q_empty,
  input logic [NUM_Q-1:0]  q_pop,
  input logic [QSEL_W-1:0] out_sel,
  input logic              sector_sel,
  input logic              proto_err,
  input logic              q_sel_evt
);

  logic id_ok;
  assign id_ok = rd_addr[ADDR_W-1 -: ID_W] == dev_id;

  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_pop)); // R9
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop & q_empty) == '0); // R5
  AST_DRAIN_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    q_sel_evt |=> ((|q_pop) == !q_empty[out_sel])); // R2
  AST_FILL_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    q_sel_evt |=> ##1 ((|q_pop) == !q_empty[out_sel])); // R3
  AST_SEL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    q_sel_evt |=> ##1 (out_sel == $past(rd_addr[QSEL_W-1:0], 2))); // R1
  AST_SECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sect_stb && !addr_stb && id_ok) |=> (sector_sel == $past(rd_addr[0]))); // R6
  AST_SECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sect_stb && !addr_stb && id_ok) |=> $stable(sector_sel)); // R7
  AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_stb && sect_stb) |=> proto_err); // R8
  AST_CLASH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_stb && sect_stb) |=> !proto_err); // R8

endmodule

bind rd_queue_sel rqs_checker #(.ADDR_W(ADDR_W), .ID_W(ID_W), .NUM_Q(NUM_Q)) u_chk (.*);

// File: tb/rd_queue_sel_tb.sv
module rd_queue_sel_tb;

  localparam int NQ = 16;
  localparam logic [2:0] MYID = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        addr_stb = 1'b0, sect_stb = 1'b0, rd_en = 1'b0;
  logic [2:0]  dev_id = MYID;
  logic [NQ-1:0] q_empty;
  logic [NQ-1:0] q_pop;
  logic [3:0]  out_sel;
  logic        sector_sel, proto_err;

  int errs = 0, checks = 0;
  bit done = 0;

  logic [15:0] fifo [NQ][$];
  logic [15:0] dout = '0;
  logic [NQ-1:0] pop_snap = '0;
  logic [15:0] exp_w [$];
  string       exp_tag [$];

  always #2.5 clk = ~clk;

  rd_queue_sel u_dut (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .addr_stb(addr_stb),
    .sect_stb(sect_stb), .rd_en(rd_en), .dev_id(dev_id), .q_empty(q_empty),
    .q_pop(q_pop), .out_sel(out_sel), .sector_sel(sector_sel), .proto_err(proto_err)
  );

  function automatic logic [NQ-1:0] empties();
    logic [NQ-1:0] e;
    for (int i = 0; i < NQ; i++) e[i] = (fifo[i].size() == 0);
    return e;
  endfunction

  always @(negedge clk) pop_snap = q_pop;

  // storage and output register model, plus scoreboard monitor
  always @(posedge clk) begin
    for (int i = 0; i < NQ; i++) begin
      if (pop_snap[i] && fifo[i].size() > 0) begin
        dout = fifo[i].pop_front();
        checks++;
        if (exp_w.size() == 0) begin
          errs++;
          $display("FAIL scoreboard: unexpected load actual=%h expected=none", dout);
        end else begin
          string t;
          logic [15:0] w;
          w = exp_w.pop_front();
          t = exp_tag.pop_front();
          if (w !== dout) begin
            errs++;
            $display("FAIL %s scoreboard: actual=%h expected=%h", t, dout, w);
          end
        end
      end
    end
    q_empty = empties();
  end

  task automatic expect_load(input logic [15:0] w, input string tag);
    exp_w.push_back(w);
    exp_tag.push_back(tag);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] qaddr(input logic [2:0] id, input logic [3:0] q);
    return {id, 1'b0, q};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NQ; i++)
      if (i != 9)
        for (int k = 0; k < 6; k++) fifo[i].push_back({i[7:0], k[7:0]});
    q_empty = empties();
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R9 reset state
    chk("R9 pop idle", q_pop, 0);
    chk("R9 out_sel", out_sel, 0);
    chk("R9 sector", sector_sel, 0);
    chk("R9 proto_err", proto_err, 0);

    // R4 plain reads from queue 0
    rd_en = 1;
    expect_load(16'h0000, "R4"); step(); chk("R4 read0", dout, 16'h0000);
    expect_load(16'h0001, "R4"); step(); chk("R4 read1", dout, 16'h0001);
    expect_load(16'h0002, "R4"); step(); chk("R4 read2", dout, 16'h0002);
    rd_en = 0;
    step(); chk("R4 idle hold", dout, 16'h0002);

    // R1 R2 R3 switch to queue 5 without rd_en
    rd_addr = qaddr(MYID, 4'd5); addr_stb = 1;
    step(); addr_stb = 0;
    chk("R1 select edge no load", dout, 16'h0002);
    expect_load(16'h0003, "R2"); step(); chk("R2 old queue word", dout, 16'h0003);
    expect_load(16'h0500, "R3"); step(); chk("R3 new head", dout, 16'h0500);
    chk("R1 out_sel", out_sel, 5);
    step(); chk("R3 no extra load", dout, 16'h0500);

    // switch to queue 7 with rd_en held
    rd_en = 1; rd_addr = qaddr(MYID, 4'd7); addr_stb = 1;
    expect_load(16'h0501, "R1"); step(); addr_stb = 0;
    chk("R1 select edge read", dout, 16'h0501);
    expect_load(16'h0502, "R2"); step(); chk("R2 drain with rd_en", dout, 16'h0502);
    expect_load(16'h0700, "R3"); step(); chk("R3 head with rd_en", dout, 16'h0700);
    expect_load(16'h0701, "R4"); step(); chk("R4 after switch", dout, 16'h0701);
    rd_en = 0;

    // R7 foreign device number
    rd_addr = qaddr(3'd2, 4'd3); addr_stb = 1;
    step(); addr_stb = 0;
    step(); step();
    chk("R7 queue kept", out_sel, 7);
    chk("R7 no forced pop", dout, 16'h0701);
    rd_addr = {3'd2, 5'b00001}; sect_stb = 1;
    step(); sect_stb = 0;
    chk("R7 sector kept", sector_sel, 0);

    // R6 sector select
    rd_addr = {MYID, 5'b11101}; sect_stb = 1;
    step(); sect_stb = 0;
    chk("R6 sector one", sector_sel, 1);
    chk("R6 no read", dout, 16'h0701);
    rd_addr = {MYID, 5'b11100}; sect_stb = 1;
    step(); sect_stb = 0;
    chk("R6 sector zero", sector_sel, 0);
    rd_addr = {MYID, 5'b00001}; sect_stb = 1; rd_en = 1;
    expect_load(16'h0702, "R6"); step(); sect_stb = 0; rd_en = 0;
    chk("R6 sector with read", sector_sel, 1);
    chk("R6 read same edge", dout, 16'h0702);

    // R8 both strobes: queue 2 selected, sector unchanged
    rd_addr = qaddr(MYID, 4'd2); addr_stb = 1; sect_stb = 1;
    step(); addr_stb = 0; sect_stb = 0;
    chk("R8 proto_err set", proto_err, 1);
    chk("R8 sector kept", sector_sel, 1);
    expect_load(16'h0703, "R8"); step();
    chk("R8 proto_err clear", proto_err, 0);
    expect_load(16'h0200, "R8"); step();
    chk("R8 select carried out", dout, 16'h0200);

    // R5 switch into empty queue 9
    rd_addr = qaddr(MYID, 4'd9); addr_stb = 1;
    step(); addr_stb = 0;
    expect_load(16'h0201, "R2"); step(); chk("R2 drain before empty", dout, 16'h0201);
    step(); chk("R5 empty head hold", dout, 16'h0201);
    chk("R5 out_sel", out_sel, 9);
    rd_en = 1; #1;
    chk("R5 no pop on empty", q_pop, 0);
    step(); rd_en = 0;
    chk("R5 read empty hold", dout, 16'h0201);

    chk("R4 scoreboard drained", exp_w.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule